// File: doc/BRIEF.md
# Prescaled Compare Timer with PWM Output

This block is a free-running up-counter with a small register interface. Software can start and stop it, slow it with a power-of-two prescaler, and set it to reload from a load value or stop when it passes all-ones. It can also flag the cycle in which the count steps onto a programmed match value. Overflow and match events latch into status bits that software clears by writing ones. A per-bit enable mask combines these status bits into one interrupt line.

A waveform output follows the counter events. It can react to overflow alone, or to overflow and match together. In pulse style it inverts for one cycle per event. In toggle style it flips on each event. While the timer is stopped or no trigger source is selected, it rests at a programmable level. Writes to the control, count, load, reload-trigger and match registers are posted. Each lands two clocks after the bus write, and a per-register pending bit stays high until then. Status and enable writes take effect at once.

Top module: `cmp_pwm_timer`

## Requirements
- R1: After reset every readable register reads 0, and `irq` and `pwm_out` are 0.
- R2: A write to address 0 (control), 1 (count), 2 (load), 3 (reload trigger) or 4 (match) raises pending bit 0, 1, 2, 3 or 4 of the word read at address 7. That bit is visible from the clock edge that takes the write. At the second edge after the write, the value takes effect and the pending bit clears.
- R3: Control bit 0 runs the counter. With control bit 2 clear, the counter rises by one every clock. With bit 2 set, it rises once every 2^(d+1) clocks, where d is control bits 5:3. While stopped, the count holds.
- R4: With control bit 1 set, a step from all-ones loads the value of the load register and sets status bit 1 (overflow).
- R5: With control bit 1 clear, a step from all-ones wraps the count to 0, sets status bit 1 and clears control bit 0.
- R6: When a write to address 3 takes effect, the count is reloaded from the load register, whatever value was written.
- R7: With control bit 6 set, status bit 0 (match) sets at the edge where the count steps onto the value of the match register. With bit 6 clear it never sets.
- R8: Status is read at address 5. Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R9: `irq` is high whenever a status bit is set and the matching bit of the enable register (address 6, bits 1:0) is also set.
- R10: `pwm_out` equals control bit 7 (idle level) in three cases: the timer is stopped, the trigger mode (control bits 9:8) is 0, or the trigger mode is 3.
- R11: Trigger mode 1 reacts to overflow, and mode 2 reacts to overflow and match. With control bit 10 clear (pulse style), `pwm_out` is the inverse of the idle level for the one cycle after each event edge.
- R12: With control bit 10 set (toggle style), `pwm_out` starts at the idle level and inverts at each event edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (3) | Register word address |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Combined interrupt request |
| pwm_out | output | 1 | Trigger waveform output |

## Verification
An overflow event can land in the same cycle as a software write that clears the overflow status bit. The bench provokes this by using a reload period of sixteen steps and timing a write-one-to-clear so that the controller takes it on the exact edge of the second overflow. It expects the bit to read 1 afterwards with `irq` still high. A later clear that falls between overflows must then read 0 and drop `irq`.

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer #(
  parameter int CW = 32,
  parameter int DW = 3,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq,
  output logic          pwm_out
);

  localparam int NPOST = 5;
  localparam int PSW   = 1 << DW;
  localparam int B_DIV = 3;
  localparam int B_CEN = 3 + DW;
  localparam int B_IDL = 4 + DW;
  localparam int B_TM  = 5 + DW;
  localparam int B_TGL = 7 + DW;
  localparam int CTLW  = 8 + DW;

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CNT  = AW'(1);
  localparam logic [AW-1:0] A_LOAD = AW'(2);
  localparam logic [AW-1:0] A_TRIG = AW'(3);
  localparam logic [AW-1:0] A_MTCH = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);
  localparam logic [AW-1:0] A_IEN  = AW'(6);
  localparam logic [AW-1:0] A_PEND = AW'(7);

  logic [NPOST-1:0] wsel, pa, pb, pend;
  logic [CW-1:0]    stg [NPOST];
  logic [CTLW-1:0]  ctl;
  logic [CW-1:0]    cnt, ld, mt, step_val;
  logic [PSW-1:0]   psc, lim;
  logic [PSW:0]     lim_w;
  logic [1:0]       st, ien, clr;
  logic             tick, full, ovf_ev, match_ev, trg_ev, active;
  logic             pls_q, tog_q;

  logic          run, ar, pre, cen, idl, tgl;
  logic [DW-1:0] div;
  logic [1:0]    tmode;

  assign run   = ctl[0];
  assign ar    = ctl[1];
  assign pre   = ctl[2];
  assign div   = ctl[B_DIV +: DW];
  assign cen   = ctl[B_CEN];
  assign idl   = ctl[B_IDL];
  assign tmode = ctl[B_TM +: 2];
  assign tgl   = ctl[B_TGL];

  always_comb begin
    for (int i = 0; i < NPOST; i++) wsel[i] = bus_we && (bus_addr == AW'(i));
  end

  assign pend = pa | pb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa <= '0;
      pb <= '0;
      for (int i = 0; i < NPOST; i++) stg[i] <= '0;
    end else begin
      pa <= wsel;
      pb <= pa;
      for (int i = 0; i < NPOST; i++) if (wsel[i]) stg[i] <= bus_wdata;
    end
  end

  assign lim_w = ({{PSW{1'b0}}, 1'b1} << ({1'b0, div} + 1'b1)) - 1'b1;
  assign lim   = lim_w[PSW-1:0];

  assign tick     = run && (!pre || psc == lim);
  assign full     = &cnt;
  assign step_val = full ? (ar ? ld : '0) : cnt + 1'b1;
  assign ovf_ev   = tick && full;
  assign match_ev = cen && tick && (step_val == mt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc <= '0;
    else if (!run || !pre || psc == lim) psc <= '0;
    else psc <= psc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else if (pb[0]) ctl <= stg[0][CTLW-1:0];
    else if (ovf_ev && !ar) ctl[0] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ld  <= '0;
      mt  <= '0;
    end else begin
      if (pb[1]) cnt <= stg[1];
      else if (pb[3]) cnt <= ld;
      else if (tick) cnt <= step_val;
      if (pb[2]) ld <= stg[2];
      if (pb[4]) mt <= stg[4];
    end
  end

  assign clr = (bus_we && bus_addr == A_STAT) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= '0;
      ien <= '0;
    end else begin
      st <= (st & ~clr) | {ovf_ev, match_ev};
      if (bus_we && bus_addr == A_IEN) ien <= bus_wdata[1:0];
    end
  end

  assign irq = |(st & ien);

  assign active = run && (tmode == 2'd1 || tmode == 2'd2);
  assign trg_ev = (tmode == 2'd1 && ovf_ev) || (tmode == 2'd2 && (ovf_ev || match_ev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pls_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      pls_q <= trg_ev;
      tog_q <= active ? (tog_q ^ trg_ev) : 1'b0;
    end
  end

  assign pwm_out = active ? (idl ^ (tgl ? tog_q : pls_q)) : idl;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = CW'(ctl);
      A_CNT:   bus_rdata = cnt;
      A_LOAD:  bus_rdata = ld;
      A_TRIG:  bus_rdata = '0;
      A_MTCH:  bus_rdata = mt;
      A_STAT:  bus_rdata = CW'(st);
      A_IEN:   bus_rdata = CW'(ien);
      A_PEND:  bus_rdata = CW'(pend);
      default: bus_rdata = '0;
    endcase
  end

  AST_PEND_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|wsel) |=> ((pend & $past(wsel)) == $past(wsel))); // R2
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pb[2] && !pa[2] && !wsel[2]) |=> !pend[2]); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pb[1] && !pb[3]) |=> $stable(cnt)); // R3
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !ar && !pb[0]) |=> !run); // R5
  AST_MATCH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[0]) |-> $past(match_ev)); // R7
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[1] && !ovf_ev) |=> !st[1]); // R8
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || tmode == 2'd0 || tmode == 2'd3) |-> (pwm_out == idl)); // R10

endmodule

// File: tb/cmp_pwm_timer_test.sv
`timescale 1ns/1ps
module cmp_pwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, pwm_out;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] CTRL = 0, CNT = 1, LOAD = 2, TRIG = 3, MTCH = 4, STAT = 5, IEN = 6, PEND = 7;

  cmp_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_wait(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic setup(input logic [31:0] c, input logic [31:0] l, input logic [31:0] m, input logic [31:0] ctl);
    wr_wait(CTRL, 32'h0);
    wr(STAT, 32'h3);
    wr_wait(CNT, c);
    wr_wait(LOAD, l);
    wr_wait(MTCH, m);
    wr_wait(CTRL, ctl);
  endtask

  function automatic logic [31:0] exp_count(input logic [31:0] s, input int k, input bit pre, input int d);
    return pre ? s + 32'(k >> (d + 1)) : s + 32'(k);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7319));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg after reset", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 pwm after reset", {31'b0, pwm_out}, 0);

    wr(LOAD, 32'h1234);
    rd(PEND, v); chk("R2 pend at write edge", v, 32'h4);
    rd(LOAD, v); chk("R2 load not yet", v, 32'h0);
    @(negedge clk);
    rd(PEND, v); chk("R2 pend one later", v, 32'h4);
    rd(LOAD, v); chk("R2 load still old", v, 32'h0);
    @(negedge clk);
    rd(PEND, v); chk("R2 pend cleared", v, 32'h0);
    rd(LOAD, v); chk("R2 load landed", v, 32'h1234);

    wr(TRIG, 32'h0);
    rd(PEND, v); chk("R2 trigger pend bit 3", v, 32'h8);
    repeat (2) @(negedge clk);
    rd(CNT, v); chk("R6 reload from load", v, 32'h1234);

    setup(32'd10, 32'd0, 32'd0, 32'h1);
    rd(CNT, v); chk("R3 count at start", v, 32'd10);
    repeat (7) @(negedge clk);
    rd(CNT, v); chk("R3 count plain", v, 32'd17);
    wr_wait(CTRL, 32'h0);
    rd(CNT, v);
    repeat (5) @(negedge clk);
    begin logic [31:0] w; rd(CNT, w); chk("R3 hold while stopped", w, v); end

    setup(32'd0, 32'd0, 32'd0, 32'h1D);
    repeat (15) @(negedge clk);
    rd(CNT, v); chk("R3 prescale d=3 before", v, 32'd0);
    @(negedge clk);
    rd(CNT, v); chk("R3 prescale d=3 first", v, 32'd1);
    repeat (16) @(negedge clk);
    rd(CNT, v); chk("R3 prescale d=3 second", v, 32'd2);

    setup(32'hFFFF_FFFE, 32'h55, 32'h0, 32'h3);
    @(negedge clk);
    rd(CNT, v); chk("R4 at all-ones", v, 32'hFFFF_FFFF);
    rd(STAT, v); chk("R4 no ovf yet", v, 32'h0);
    @(negedge clk);
    rd(CNT, v); chk("R4 reloaded", v, 32'h55);
    rd(STAT, v); chk("R4 ovf flag", v, 32'h2);

    setup(32'hFFFF_FFFE, 32'h55, 32'h0, 32'h1);
    repeat (2) @(negedge clk);
    rd(CNT, v); chk("R5 wrapped to zero", v, 32'h0);
    rd(STAT, v); chk("R5 ovf flag", v, 32'h2);
    rd(CTRL, v); chk("R5 run cleared", v, 32'h0);
    repeat (3) @(negedge clk);
    rd(CNT, v); chk("R5 stays stopped", v, 32'h0);

    setup(32'd100, 32'd0, 32'd103, 32'h41);
    repeat (2) @(negedge clk);
    rd(STAT, v); chk("R7 no match early", v, 32'h0);
    @(negedge clk);
    rd(STAT, v); chk("R7 match flag", v, 32'h1);
    setup(32'd100, 32'd0, 32'd103, 32'h1);
    repeat (5) @(negedge clk);
    rd(STAT, v); chk("R7 compare disabled", v, 32'h0);

    setup(32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h0, 32'h3);
    repeat (16) @(negedge clk);
    rd(STAT, v); chk("R8 first ovf", v, 32'h2);
    chk("R9 masked irq", {31'b0, irq}, 0);
    wr(IEN, 32'h2);
    chk("R9 enabled irq", {31'b0, irq}, 1);
    repeat (14) @(negedge clk);
    wr(STAT, 32'h2);
    rd(STAT, v); chk("R8 set wins over clear", v, 32'h2);
    chk("R9 irq held", {31'b0, irq}, 1);
    repeat (7) @(negedge clk);
    wr(STAT, 32'h2);
    rd(STAT, v); chk("R8 clear between events", v, 32'h0);
    chk("R9 irq dropped", {31'b0, irq}, 0);
    wr(STAT, 32'h0);
    rd(STAT, v); chk("R8 write zero no effect", v, 32'h0);

    setup(32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h0, 32'h103);
    repeat (15) @(negedge clk);
    chk("R11 pulse low before", {31'b0, pwm_out}, 0);
    @(negedge clk);
    chk("R11 pulse on ovf", {31'b0, pwm_out}, 1);
    @(negedge clk);
    chk("R11 pulse one cycle", {31'b0, pwm_out}, 0);

    setup(32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'hFFFF_FFF4, 32'h243);
    repeat (3) @(negedge clk);
    chk("R11 mode2 before match", {31'b0, pwm_out}, 0);
    @(negedge clk);
    chk("R11 mode2 match pulse", {31'b0, pwm_out}, 1);
    @(negedge clk);
    chk("R11 mode2 after match", {31'b0, pwm_out}, 0);
    repeat (11) @(negedge clk);
    chk("R11 mode2 ovf pulse", {31'b0, pwm_out}, 1);

    setup(32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h0, 32'h583);
    chk("R12 toggle starts idle", {31'b0, pwm_out}, 1);
    repeat (15) @(negedge clk);
    chk("R12 toggle before", {31'b0, pwm_out}, 1);
    @(negedge clk);
    chk("R12 toggle first", {31'b0, pwm_out}, 0);
    repeat (15) @(negedge clk);
    chk("R12 toggle holds", {31'b0, pwm_out}, 0);
    @(negedge clk);
    chk("R12 toggle second", {31'b0, pwm_out}, 1);

    setup(32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h0, 32'h80);
    chk("R10 stopped idle high", {31'b0, pwm_out}, 1);
    setup(32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h0, 32'h383);
    repeat (16) @(negedge clk);
    chk("R10 reserved mode idle", {31'b0, pwm_out}, 1);
    setup(32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h0, 32'h003);
    repeat (16) @(negedge clk);
    chk("R10 mode0 idle low", {31'b0, pwm_out}, 0);

    for (int n = 0; n < 16; n++) begin
      int d = int'($urandom % 8);
      bit pre = 1'($urandom % 2);
      int k = 20 + int'($urandom % 600);
      logic [31:0] s = $urandom & 32'h0FFF_FFFF;
      wr_wait(CTRL, 32'h0);
      wr_wait(CNT, s);
      wr_wait(CTRL, 32'h1 | (32'(pre) << 2) | (32'(d) << 3));
      repeat (k) @(negedge clk);
      rd(CNT, v);
      chk("R3 random prescale", v, exp_count(s, k, pre, d));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule